// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block holds the software-visible state of one bank of general-purpose pins: the value each pin drives, whether the pin is an output, and whether its driver is switched on. Software reaches it over a simple register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Each pin's tri-state enable is the AND of its direction bit and its driver-enable bit. The pin drive value comes straight from the output data register.

Two write-only half-word ports let software change any chosen subset of pins in one write, with no read-modify-write. Each port controls sixteen pins. The upper sixteen bits of the write word are a keep-mask: a 1 protects the matching output bit. The lower sixteen bits carry the new values. A full-word data register can also be written and read directly. A read-only register shows the pin levels after a two-flop synchroniser.

The reset input is asserted asynchronously and released synchronously inside the block. The address map moves with the bank index parameter, so one bank instance can be placed at any bank slot of a larger controller.

Top module: `gpio_bank_top`

## Requirements
- R1: While reset is applied, and after it is released, the output data, direction and driver-enable registers are all zero. `pin_out` and `pin_oe` are zero, and `bus_rdata` is zero.
- R2: A write to the low half-word port at byte offset 8*BANK updates output bit i (i = 0..15) from `bus_wdata[i]` only where `bus_wdata[16+i]` is 0. All other output bits keep their values.
- R3: A write to the high half-word port at byte offset 8*BANK+4 updates output bit 16+i from `bus_wdata[i]` only where `bus_wdata[16+i]` is 0. Bits 0..15 and all protected bits keep their values.
- R4: The full-word data register at offset 0x040+4*BANK replaces all 32 output bits with the write data. A read of it returns the current output register.
- R5: The sample register at offset 0x060+4*BANK returns the pin inputs after two synchroniser flops. A level present before clock edge k is returned by a read strobed at edge k+2, not by one strobed at edge k or k+1. A write to this offset changes no state.
- R6: The direction register at offset 0x204+0x40*BANK can be read and written. Bit value 1 marks the pin as an output.
- R7: The driver-enable register at offset 0x208+0x40*BANK can be read and written. Bit value 1 switches the pin's driver on.
- R8: `pin_oe` equals direction AND driver-enable, bit by bit. `pin_out` equals the output data register. Neither output changes in a cycle that follows no bus write.
- R9: A read of either half-word port, or of any unmapped offset, returns zero. A write to an unmapped offset changes no register.
- R10: `bus_rdata` is loaded at the clock edge where `bus_rd` is high, from the register state before that edge. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin driver enables |

## Verification
The checker verifies several properties on every cycle:
- a half-word port write never disturbs the other half of the output word;
- an all-ones keep-mask leaves the outputs untouched;
- a full-word write lands exactly;
- writes to the sample offset have no effect;
- the pin outputs and read data stay frozen when no access happens;
- half-port reads return zero.

Some behaviours need the bench's scenarios, because they depend on modelled state:
- the exact merge of kept and replaced bits under random masks;
- the two-edge synchroniser delay measured by back-to-back reads;
- the AND of direction and driver-enable across random patterns;
- the read-back of each register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HALF_LO,
    SEL_HALF_HI,
    SEL_WORD,
    SEL_SAMPLE,
    SEL_DIR,
    SEL_DRVEN
  } reg_sel_e;

  function automatic int off_half_lo(input int bank);
    return 8 * bank;
  endfunction

  function automatic int off_half_hi(input int bank);
    return 8 * bank + 4;
  endfunction

  function automatic int off_word(input int bank);
    return 'h40 + 4 * bank;
  endfunction

  function automatic int off_sample(input int bank);
    return 'h60 + 4 * bank;
  endfunction

  function automatic int off_dir(input int bank);
    return 'h204 + 'h40 * bank;
  endfunction

  function automatic int off_drven(input int bank);
    return 'h208 + 'h40 * bank;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(off_half_lo(BANK));
  localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(off_half_hi(BANK));
  localparam logic [ADDR_W-1:0] A_WORD  = ADDR_W'(off_word(BANK));
  localparam logic [ADDR_W-1:0] A_SAMP  = ADDR_W'(off_sample(BANK));
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(off_dir(BANK));
  localparam logic [ADDR_W-1:0] A_DRVEN = ADDR_W'(off_drven(BANK));

  always_comb begin
    sel = SEL_NONE;
    if      (addr == A_LO)    sel = SEL_HALF_LO;
    else if (addr == A_HI)    sel = SEL_HALF_HI;
    else if (addr == A_WORD)  sel = SEL_WORD;
    else if (addr == A_SAMP)  sel = SEL_SAMPLE;
    else if (addr == A_DIR)   sel = SEL_DIR;
    else if (addr == A_DRVEN) sel = SEL_DRVEN;
  end

endmodule

// File: rtl/gpio_bank_store.sv
module gpio_bank_store
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [WORD_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] data_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] drven_q
);

  localparam int HALF = NUM_PINS / 2;

  logic [HALF-1:0]     merged [2];
  logic [NUM_PINS-1:0] data_d, dir_d, drven_d;
  logic                data_we, dir_we, drven_we;

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF-1:0] keep_m;
      logic [HALF-1:0] old_bits;
      assign keep_m     = wdata[2*HALF-1:HALF];
      assign old_bits   = data_q[h*HALF +: HALF];
      assign merged[h]  = (old_bits & keep_m) | (wdata[HALF-1:0] & ~keep_m);
    end
  endgenerate

  always_comb begin
    data_we = 1'b0;
    data_d  = data_q;
    if (wr_en) begin
      case (sel)
        SEL_HALF_LO: begin
          data_we = 1'b1;
          data_d  = {data_q[NUM_PINS-1:HALF], merged[0]};
        end
        SEL_HALF_HI: begin
          data_we = 1'b1;
          data_d  = {merged[1], data_q[HALF-1:0]};
        end
        SEL_WORD: begin
          data_we = 1'b1;
          data_d  = wdata[NUM_PINS-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    dir_we   = wr_en && (sel == SEL_DIR);
    drven_we = wr_en && (sel == SEL_DRVEN);
    dir_d    = wdata[NUM_PINS-1:0];
    drven_d  = wdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      drven_q <= '0;
    end else begin
      if (data_we)  data_q  <= data_d;
      if (dir_we)   dir_q   <= dir_d;
      if (drven_we) drven_q <= drven_d;
    end
  end

endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK        = 0,
  parameter int NUM_PINS    = 32,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] data_q, dir_q, drven_q, sampled;
  logic [WORD_W-1:0]   rd_val, rdata_q;

  gpio_bank_decode #(.ADDR_W(ADDR_W), .BANK(BANK)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_bank_store #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (bus_wr),
    .sel     (sel),
    .wdata   (bus_wdata),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .drven_q (drven_q)
  );

  gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (pin_in),
    .sync_out (sampled)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_WORD:   rd_val = WORD_W'(data_q);
      SEL_SAMPLE: rd_val = WORD_W'(sampled);
      SEL_DIR:    rd_val = WORD_W'(dir_q);
      SEL_DRVEN:  rd_val = WORD_W'(drven_q);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  rdata_q <= '0;
    else if (bus_rd)  rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = data_q;
  assign pin_oe    = dir_q & drven_q;

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK     = 0,
  parameter int NUM_PINS = 32,
  parameter int WORD_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [WORD_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  localparam int HALF = NUM_PINS / 2;
  localparam logic [ADDR_W-1:0] C_LO   = ADDR_W'(off_half_lo(BANK));
  localparam logic [ADDR_W-1:0] C_HI   = ADDR_W'(off_half_hi(BANK));
  localparam logic [ADDR_W-1:0] C_WORD = ADDR_W'(off_word(BANK));
  localparam logic [ADDR_W-1:0] C_SAMP = ADDR_W'(off_sample(BANK));

  assert_lo_keeps_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_LO) |=> $stable(pin_out[NUM_PINS-1:HALF]));

  assert_full_mask_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == C_LO || bus_addr == C_HI) && (&bus_wdata[2*HALF-1:HALF]))
      |=> $stable(pin_out));

  assert_hi_keeps_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_HI) |=> $stable(pin_out[HALF-1:0]));

  assert_word_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_WORD) |=> (pin_out == $past(bus_wdata[NUM_PINS-1:0])));

  assert_sample_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_SAMP) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_half_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == C_LO || bus_addr == C_HI)) |=> (bus_rdata == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_bank_top gpio_bank_checker #(
  .ADDR_W(ADDR_W), .BANK(BANK), .NUM_PINS(NUM_PINS), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/gpio_bank_top_test.sv
`timescale 1ns/1ps
module gpio_bank_top_test;

  localparam logic [11:0] A_LO    = 12'h000;
  localparam logic [11:0] A_HI    = 12'h004;
  localparam logic [11:0] A_WORD  = 12'h040;
  localparam logic [11:0] A_SAMP  = 12'h060;
  localparam logic [11:0] A_DIR   = 12'h204;
  localparam logic [11:0] A_DRVEN = 12'h208;
  localparam logic [11:0] A_VOID  = 12'h100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int total = 0;
  int bad   = 0;
  logic [31:0] m_data, m_dir, m_drven;

  always #2.5 clk = ~clk;

  gpio_bank_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] merge_half(input logic [31:0] old, input logic [31:0] w,
                                             input bit upper);
    logic [15:0] keep = w[31:16];
    logic [15:0] oldh = upper ? old[31:16] : old[15:0];
    logic [15:0] newh = (oldh & keep) | (w[15:0] & ~keep);
    return upper ? {newh, old[15:0]} : {old[31:16], newh};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == A_LO)    m_data  = merge_half(m_data, d, 1'b0);
    if (a == A_HI)    m_data  = merge_half(m_data, d, 1'b1);
    if (a == A_WORD)  m_data  = d;
    if (a == A_DIR)   m_dir   = d;
    if (a == A_DRVEN) m_drven = d;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv, prev, v;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    pin_in = 32'h0; m_data = '0; m_dir = '0; m_drven = '0;
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", pin_out, 32'h0);
    check("R1 pin_oe in reset", pin_oe, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    bus_read(A_WORD, rv);  check("R1 data reg", rv, 32'h0);
    bus_read(A_DIR, rv);   check("R1 dir reg", rv, 32'h0);
    bus_read(A_DRVEN, rv); check("R1 drven reg", rv, 32'h0);

    // R4 full word write and read back
    for (int i = 0; i < 6; i++) begin
      v = $urandom();
      bus_write(A_WORD, v);
      check("R4 pin_out", pin_out, m_data);
      bus_read(A_WORD, rv);
      check("R4 readback", rv, m_data);
    end

    // R2 directed: only bit 0 changes
    bus_write(A_WORD, 32'hFFFF_FFFF);
    bus_write(A_LO, 32'hFFFE_0000);
    check("R2 single pin clear", pin_out, 32'hFFFF_FFFE);
    // R3 directed: high port data bit 15 drives pin 31
    bus_write(A_WORD, 32'h0);
    bus_write(A_HI, 32'h7FFF_8000);
    check("R3 pin 31 set", pin_out, 32'h8000_0000);
    bus_write(A_HI, 32'hFFFF_FFFF);
    check("R3 full keep mask", pin_out, 32'h8000_0000);

    // R2/R3 random masked writes
    for (int i = 0; i < 40; i++) begin
      v = $urandom();
      if (i % 2 == 0) begin
        bus_write(A_LO, v);
        check("R2 masked low write", pin_out, m_data);
      end else begin
        bus_write(A_HI, v);
        check("R3 masked high write", pin_out, m_data);
      end
    end

    // R9 half ports and unmapped offsets read as zero, unmapped write ignored
    bus_read(A_LO, rv);   check("R9 low port read", rv, 32'h0);
    bus_read(A_HI, rv);   check("R9 high port read", rv, 32'h0);
    bus_read(A_VOID, rv); check("R9 unmapped read", rv, 32'h0);
    bus_write(A_VOID, 32'hA5A5_5A5A);
    check("R9 unmapped write pin_out", pin_out, m_data);
    bus_read(A_DIR, rv);  check("R9 unmapped write dir", rv, m_dir);

    // R6 R7 R8 direction and driver enable
    bus_write(A_DIR, 32'hFFFF_0000);
    bus_write(A_DRVEN, 32'h00FF_00FF);
    check("R8 oe directed", pin_oe, 32'h00FF_0000);
    for (int i = 0; i < 8; i++) begin
      bus_write(A_DIR, $urandom());
      bus_write(A_DRVEN, $urandom());
      check("R8 oe and", pin_oe, m_dir & m_drven);
      check("R8 out value", pin_out, m_data);
      bus_read(A_DIR, rv);   check("R6 dir readback", rv, m_dir);
      bus_read(A_DRVEN, rv); check("R7 drven readback", rv, m_drven);
    end

    // R5 synchroniser delay and sample read
    pin_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    pin_in = 32'hCAFE_F00D;
    bus_read(A_SAMP, rv); check("R5 edge k old", rv, 32'h1234_5678);
    bus_read(A_SAMP, rv); check("R5 edge k+1 old", rv, 32'h1234_5678);
    bus_read(A_SAMP, rv); check("R5 edge k+2 new", rv, 32'hCAFE_F00D);
    for (int i = 0; i < 6; i++) begin
      v = $urandom();
      pin_in = v;
      repeat (3) @(negedge clk);
      bus_read(A_SAMP, rv);
      check("R5 random sample", rv, v);
    end
    bus_write(A_SAMP, 32'hFFFF_FFFF);
    check("R5 sample write out", pin_out, m_data);
    check("R5 sample write oe", pin_oe, m_dir & m_drven);
    bus_read(A_SAMP, rv); check("R5 sample after write", rv, v);

    // R10 read data holds without read strobe
    bus_read(A_DIR, prev);
    bus_write(A_DIR, ~prev);
    repeat (2) @(negedge clk);
    check("R10 rdata hold", bus_rdata, prev);
    bus_read(A_DIR, rv);
    check("R10 new read", rv, ~prev);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule